// File: doc/BRIEF.md
# Split-Word Interrupt Register Controller

This block gathers 51 interrupt sources and routes each one to one of two processor lines. The normal line is `irq_o` and the fast line is `fiq_o`. Software works with it through a 32-bit register bus. Each 51-bit piece of controller state is shown as two words. The low word holds sources 0 to 31. The high word holds sources 32 to 50, and only its bottom 19 bits are used. Address bit 2 picks between the two words.

Trigger detection for each source happens outside this block. A level-sensitive source sends its already-polarised request on `src_level`. An edge-sensitive source sends a one-cycle pulse on `src_set`.

The sensitivity map is fixed at reset. For edge sources the controller keeps a sticky pending bit, which software clears by writing ones. Enables have one address that sets bits and a second address that clears them, so software never needs a read-modify-write. A select bit for each source chooses which output line the source drives.

Top module: `split_irq_ctrl`

## Requirements
- R1: After reset these registers read as follows. The sensitivity register reads 0x1F07FFF8FFFF (bit = 1 means level, bit = 0 means edge). The both-edge register reads 0xF800070000. The polarity register reads 0x5F07FFF8FFFF. Raw, enable and select read zero, and both outputs are low.
- R2: Word choice depends on the address. At an address of 0x80 or above, address bit 2 = 1 selects the high word. The high word maps its data bits 18:0 to sources 50:32. High-word reads return those 19 bits with zeros above them.
- R3: The normal-line status view at 0x80/0x84 equals raw AND enable AND NOT select. `irq_o` is high whenever any bit of that view is set.
- R4: The fast-line status view at 0x88/0x8C equals raw AND enable AND select. `fiq_o` is high whenever any bit of that view is set.
- R5: A write to 0xA0/0xA4 ORs the data into the addressed enable word. Reading either address returns the enables.
- R6: A write to 0xA8/0xAC clears every enable bit in the addressed word whose data bit is 1.
- R7: A write to the select register at 0x98/0x9C replaces only the addressed word and leaves the other word as it was.
- R8: A write to 0xD8/0xDC clears a raw bit only when both its data bit is 1 and its source is edge-sensitive. Level-sensitive raw bits are not touched.
- R9: The polarity register at 0xD0/0xD4 can be written only through the high word, and only at sources 47 to 50 (high-word bits 18:15). Writes to its low word have no effect.
- R10: For a level-sensitive source, the raw bit copies `src_level` one clock after it is sampled.
- R11: For an edge-sensitive source, a pulse on `src_set` sets the raw bit on the next clock edge. The bit stays set until it is cleared.
- R12: If a `src_set` pulse and an edge-clear write reach the same bit in the same cycle, the bit ends up set.
- R13: Reads return zero from the clear-only addresses (0xA8, 0xAC, 0xD8, 0xDC) and from unmapped addresses, including everything below 0x80. Writes to status or configuration addresses change nothing.
- R14: The edge-pending view at 0xE0/0xE4 returns raw AND NOT sensitivity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, 32-bit aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| src_set | input | 51 | Edge-detected set pulses, one bit per source |
| src_level | input | 51 | Polarised level requests, one bit per source |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
Results become visible at different times:

| Result | When it is visible |
|---|---|
| Read data | In the same cycle as the address, since it is combinational |
| Effect of a write | After the next rising edge |
| Effect of a `src_set` pulse | After the next rising edge |
| Change on `src_level` | After the next rising edge |
| `irq_o` and `fiq_o` | Combinational from those registers, so no extra delay |

The bench drives inputs on the falling edge and lets one rising edge pass. It then samples read data and output pins 1 ns after the following falling edge, so every check lands after exactly one register update. The same-cycle race between set and clear is driven in a single low phase, so both actions reach the same rising edge.

// File: rtl/split_irq_pkg.sv
package split_irq_pkg;
  localparam int NSRC = 51;
  localparam int WORD = 32;
  localparam int HI_W = NSRC - WORD;
  localparam int AW   = 8;

  // slot codes are address bits 7:3; the slot layout is software-visible
  localparam logic [4:0] SLOT_IRQ_ST  = 5'd16;
  localparam logic [4:0] SLOT_FIQ_ST  = 5'd17;
  localparam logic [4:0] SLOT_RAW     = 5'd18;
  localparam logic [4:0] SLOT_SEL     = 5'd19;
  localparam logic [4:0] SLOT_EN_SET  = 5'd20;
  localparam logic [4:0] SLOT_EN_CLR  = 5'd21;
  localparam logic [4:0] SLOT_SENSE   = 5'd24;
  localparam logic [4:0] SLOT_BOTH    = 5'd25;
  localparam logic [4:0] SLOT_POL     = 5'd26;
  localparam logic [4:0] SLOT_EDGE_CL = 5'd27;
  localparam logic [4:0] SLOT_EDGE_ST = 5'd28;

  function automatic logic [NSRC-1:0] place_word(input logic [WORD-1:0] d, input logic hi);
    return hi ? {d[HI_W-1:0], {WORD{1'b0}}} : {{HI_W{1'b0}}, d};
  endfunction

  function automatic logic [WORD-1:0] pick_word(input logic [NSRC-1:0] v, input logic hi);
    return hi ? {{(WORD-HI_W){1'b0}}, v[NSRC-1:WORD]} : v[WORD-1:0];
  endfunction

  function automatic logic [NSRC-1:0] half_mask(input logic hi);
    return hi ? {{HI_W{1'b1}}, {WORD{1'b0}}} : {{HI_W{1'b0}}, {WORD{1'b1}}};
  endfunction

  function automatic logic [NSRC-1:0] line_view(input logic [NSRC-1:0] raw,
                                                input logic [NSRC-1:0] en,
                                                input logic [NSRC-1:0] sel,
                                                input logic fast);
    return fast ? (raw & en & sel) : (raw & en & ~sel);
  endfunction
endpackage

// File: rtl/sic_regbank.sv
module sic_regbank
  import split_irq_pkg::*;
#(
  parameter logic [NSRC-1:0] POL_RST = 51'h5F07FFF8FFFF,
  parameter logic [NSRC-1:0] POL_WMASK = 51'h7800000000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_sel,
  input  logic            we_en_set,
  input  logic            we_en_clr,
  input  logic            we_pol,
  input  logic            word_hi,
  input  logic [WORD-1:0] wdata,
  output logic [NSRC-1:0] sel_q,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pol_q
);
  logic [NSRC-1:0] placed;
  logic [NSRC-1:0] keep_m;

  assign placed = place_word(wdata, word_hi);
  assign keep_m = ~half_mask(word_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
      pol_q <= POL_RST;
    end else begin
      if (we_sel)
        sel_q <= (sel_q & keep_m) | placed;
      if (we_en_set)
        en_q <= en_q | placed;
      else if (we_en_clr)
        en_q <= en_q & ~placed;
      if (we_pol)
        pol_q <= (pol_q & ~POL_WMASK) | (placed & POL_WMASK);
    end
  end

  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_en_set |=> ((en_q & $past(placed)) == $past(placed)));
  // R6
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_en_clr && !we_en_set) |=> ((en_q & $past(placed)) == '0));
  // R7
  sel_other_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_sel |=> ((sel_q & $past(keep_m)) == $past(sel_q & keep_m)));
  // R9
  pol_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pol_q & ~POL_WMASK));
endmodule

// File: rtl/sic_raw_track.sv
module sic_raw_track
  import split_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] sense,
  input  logic [NSRC-1:0] set_pulse,
  input  logic [NSRC-1:0] level_in,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] raw_q
);
  logic [NSRC-1:0] clr_edge;
  logic [NSRC-1:0] edge_nxt;

  assign clr_edge = clr_we ? (clr_bits & ~sense) : '0;
  // set is ORed last so a same-cycle set beats the clear
  assign edge_nxt = (raw_q & ~clr_edge) | set_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (sense & level_in) | (~sense & edge_nxt);
  end

  // R11 R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_pulse & ~sense)) |=> ((raw_q & $past(set_pulse & ~sense)) == $past(set_pulse & ~sense)));
  // R10
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & sense) == $past(level_in & sense)));
  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && set_pulse == '0) |=> $stable(raw_q & ~sense));
endmodule

// File: rtl/sic_route.sv
module sic_route
  import split_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] sel,
  output logic [NSRC-1:0] irq_view,
  output logic [NSRC-1:0] fiq_view,
  output logic            irq_o,
  output logic            fiq_o
);
  assign irq_view = line_view(raw, en, sel, 1'b0);
  assign fiq_view = line_view(raw, en, sel, 1'b1);
  assign irq_o    = |irq_view;
  assign fiq_o    = |fiq_view;

  // R3
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(raw & en & ~sel));
  // R4
  fiq_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> |(raw & en & sel));
endmodule

// File: rtl/sic_read_mux.sv
module sic_read_mux
  import split_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_hit,
  input  logic [4:0]      slot,
  input  logic            word_hi,
  input  logic [NSRC-1:0] irq_view,
  input  logic [NSRC-1:0] fiq_view,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] sel,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] sense,
  input  logic [NSRC-1:0] both_edge,
  input  logic [NSRC-1:0] pol,
  output logic [WORD-1:0] rdata
);
  logic [NSRC-1:0] src_vec;

  always_comb begin
    case (slot)
      SLOT_IRQ_ST:  src_vec = irq_view;
      SLOT_FIQ_ST:  src_vec = fiq_view;
      SLOT_RAW:     src_vec = raw;
      SLOT_SEL:     src_vec = sel;
      SLOT_EN_SET:  src_vec = en;
      SLOT_SENSE:   src_vec = sense;
      SLOT_BOTH:    src_vec = both_edge;
      SLOT_POL:     src_vec = pol;
      SLOT_EDGE_ST: src_vec = raw & ~sense;
      default:      src_vec = '0;
    endcase
  end

  assign rdata = rd_hit ? pick_word(src_vec, word_hi) : '0;

  // R13
  clear_slot_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_EN_CLR || slot == SLOT_EDGE_CL || !rd_hit) |-> (rdata == '0));
  // R2
  high_word_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_hi |-> (rdata[WORD-1:HI_W] == '0));
endmodule

// File: rtl/split_irq_ctrl.sv
module split_irq_ctrl
  import split_irq_pkg::*;
#(
  parameter logic [NSRC-1:0] SENSE_CFG = 51'h1F07FFF8FFFF,
  parameter logic [NSRC-1:0] BOTH_CFG  = 51'h00F800070000,
  parameter logic [NSRC-1:0] POL_RST   = 51'h5F07FFF8FFFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [WORD-1:0] bus_wdata,
  output logic [WORD-1:0] bus_rdata,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_level,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam logic [NSRC-1:0] POL_WMASK = {4'hF, {(NSRC-4){1'b0}}};

  logic            hit, wr_hit, rd_hit, word_hi;
  logic [4:0]      slot;
  logic            we_sel, we_en_set, we_en_clr, we_pol, we_edge_clr;
  logic [NSRC-1:0] sel_q, en_q, pol_q, raw_q, irq_view, fiq_view;

  assign hit     = bus_valid && bus_addr[AW-1] && (bus_addr[1:0] == 2'b00);
  assign wr_hit  = hit && bus_write;
  assign rd_hit  = hit && !bus_write;
  assign word_hi = bus_addr[2];
  assign slot    = bus_addr[AW-1:3];

  assign we_sel      = wr_hit && (slot == SLOT_SEL);
  assign we_en_set   = wr_hit && (slot == SLOT_EN_SET);
  assign we_en_clr   = wr_hit && (slot == SLOT_EN_CLR);
  assign we_pol      = wr_hit && (slot == SLOT_POL) && word_hi;
  assign we_edge_clr = wr_hit && (slot == SLOT_EDGE_CL);

  sic_regbank #(.POL_RST(POL_RST), .POL_WMASK(POL_WMASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_sel(we_sel), .we_en_set(we_en_set),
    .we_en_clr(we_en_clr), .we_pol(we_pol), .word_hi(word_hi),
    .wdata(bus_wdata), .sel_q(sel_q), .en_q(en_q), .pol_q(pol_q));

  sic_raw_track u_raw (
    .clk(clk), .rst_n(rst_n), .sense(SENSE_CFG), .set_pulse(src_set),
    .level_in(src_level), .clr_we(we_edge_clr),
    .clr_bits(place_word(bus_wdata, word_hi)), .raw_q(raw_q));

  sic_route u_route (
    .clk(clk), .rst_n(rst_n), .raw(raw_q), .en(en_q), .sel(sel_q),
    .irq_view(irq_view), .fiq_view(fiq_view), .irq_o(irq_o), .fiq_o(fiq_o));

  sic_read_mux u_rd (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .slot(slot), .word_hi(word_hi),
    .irq_view(irq_view), .fiq_view(fiq_view), .raw(raw_q), .sel(sel_q),
    .en(en_q), .sense(SENSE_CFG), .both_edge(BOTH_CFG), .pol(pol_q),
    .rdata(bus_rdata));

  // R9
  pol_low_word_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && slot == SLOT_POL && !word_hi) |=> $stable(pol_q));
  // R13
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (slot == SLOT_IRQ_ST || slot == SLOT_RAW || slot == SLOT_SENSE))
      |=> ($stable(en_q) && $stable(sel_q) && $stable(pol_q)));
endmodule

// File: tb/split_irq_ctrl_tb.sv
module split_irq_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 36;
  localparam int  WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [50:0] src_set = '0, src_level = '0;
  logic        irq_o, fiq_o;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_set(src_set), .src_level(src_level), .irq_o(irq_o), .fiq_o(fiq_o));

  // {req[3:0], wr, addr[7:0], wdata[31:0], expected read[31:0]}
  localparam logic [76:0] VEC [0:NV-1] = '{
    {4'd1,  1'b0, 8'hC0, 32'h0,        32'hFFF8FFFF}, // R1 sensitivity low
    {4'd1,  1'b0, 8'hC4, 32'h0,        32'h00001F07}, // R1 sensitivity high
    {4'd1,  1'b0, 8'hC8, 32'h0,        32'h00070000}, // R1 both-edge low
    {4'd1,  1'b0, 8'hCC, 32'h0,        32'h000000F8}, // R1 both-edge high
    {4'd1,  1'b0, 8'hD0, 32'h0,        32'hFFF8FFFF}, // R1 polarity low
    {4'd1,  1'b0, 8'hD4, 32'h0,        32'h00005F07}, // R1 polarity high
    {4'd1,  1'b0, 8'hA0, 32'h0,        32'h0},        // R1 enable zero
    {4'd5,  1'b1, 8'hA0, 32'hF0,       32'h0},
    {4'd5,  1'b0, 8'hA0, 32'h0,        32'hF0},       // R5
    {4'd6,  1'b1, 8'hA8, 32'h30,       32'h0},
    {4'd6,  1'b0, 8'hA0, 32'h0,        32'hC0},       // R6
    {4'd2,  1'b1, 8'hA4, 32'hFFFFFFFF, 32'h0},
    {4'd2,  1'b0, 8'hA4, 32'h0,        32'h0007FFFF}, // R2 19 bits only
    {4'd13, 1'b0, 8'hA8, 32'h0,        32'h0},        // R13 clear-only reads 0
    {4'd7,  1'b1, 8'h98, 32'h1234,     32'h0},
    {4'd7,  1'b1, 8'h9C, 32'h55,       32'h0},
    {4'd7,  1'b1, 8'h98, 32'hAAAA,     32'h0},
    {4'd7,  1'b0, 8'h98, 32'h0,        32'h0000AAAA}, // R7
    {4'd7,  1'b0, 8'h9C, 32'h0,        32'h00000055}, // R7 other half kept
    {4'd9,  1'b1, 8'hD0, 32'hFFFFFFFF, 32'h0},
    {4'd9,  1'b0, 8'hD0, 32'h0,        32'hFFF8FFFF}, // R9 low word ignored
    {4'd9,  1'b1, 8'hD4, 32'h0007FFFF, 32'h0},
    {4'd9,  1'b0, 8'hD4, 32'h0,        32'h0007DF07}, // R9 only bits 18:15
    {4'd9,  1'b1, 8'hD4, 32'h0,        32'h0},
    {4'd9,  1'b0, 8'hD4, 32'h0,        32'h00005F07}, // R9
    {4'd13, 1'b1, 8'hC0, 32'h0,        32'h0},
    {4'd13, 1'b0, 8'hC0, 32'h0,        32'hFFF8FFFF}, // R13 config write ignored
    {4'd13, 1'b0, 8'h40, 32'h0,        32'h0},        // R13 unmapped
    {4'd14, 1'b0, 8'hE0, 32'h0,        32'h0},        // R14
    {4'd6,  1'b1, 8'hA8, 32'hFFFFFFFF, 32'h0},
    {4'd6,  1'b1, 8'hAC, 32'h0007FFFF, 32'h0},
    {4'd6,  1'b0, 8'hA4, 32'h0,        32'h0},        // R6 high clear
    {4'd7,  1'b1, 8'h98, 32'h0,        32'h0},
    {4'd7,  1'b1, 8'h9C, 32'h0,        32'h0},
    {4'd10, 1'b0, 8'h90, 32'h0,        32'h0},        // R10 raw idle
    {4'd3,  1'b0, 8'h80, 32'h0,        32'h0}         // R3 status idle
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    #1;
  endtask

  task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
    bus_valid = 1'b0;
  endtask

  task automatic pulse_set(input int idx);
    @(negedge clk);
    src_set[idx] = 1'b1;
    @(negedge clk);
    src_set = '0;
  endtask

  initial begin
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 irq_o", {31'b0, irq_o}, 32'h0);
    check("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
    do_read(8'h90, 32'h0, "R1 raw");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) do_write(VEC[i][71:64], VEC[i][63:32]);
      else do_read(VEC[i][71:64], VEC[i][31:0], $sformatf("R%0d vec%0d", VEC[i][76:73], i));
    end

    // level source 0 through both lines
    @(negedge clk); src_level[0] = 1'b1;
    do_read(8'h90, 32'h1, "R10 level raw");
    check("R3 disabled", {31'b0, irq_o}, 32'h0);
    do_write(8'hA0, 32'h1);
    check("R3 irq_o", {31'b0, irq_o}, 32'h1);
    do_read(8'h80, 32'h1, "R3 status");
    do_write(8'h98, 32'h1);
    check("R4 fiq_o", {31'b0, fiq_o}, 32'h1);
    check("R4 irq_o low", {31'b0, irq_o}, 32'h0);
    do_read(8'h88, 32'h1, "R4 status");
    do_read(8'h80, 32'h0, "R4 irq view");
    @(negedge clk); src_level[0] = 1'b0;
    @(negedge clk); #1;
    check("R10 level drop", {31'b0, fiq_o}, 32'h0);

    // edge source 16
    pulse_set(16);
    do_read(8'h90, 32'h00010000, "R11 sticky");
    repeat (3) @(negedge clk);
    do_read(8'h90, 32'h00010000, "R11 still set");
    do_read(8'hE0, 32'h00010000, "R14 edge view");
    src_level[0] = 1'b1;
    do_write(8'hD8, 32'h00010001);
    do_read(8'h90, 32'h1, "R8 level untouched");
    src_level[0] = 1'b0;

    // same-cycle set and clear
    @(negedge clk);
    src_set[16] = 1'b1;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'hD8; bus_wdata = 32'h00010000;
    @(negedge clk);
    src_set = '0; bus_valid = 1'b0; bus_write = 1'b0;
    do_read(8'h90, 32'h00010000, "R12 set wins");
    do_write(8'hD8, 32'h00010000);
    do_read(8'h90, 32'h0, "R8 edge cleared");

    // high word edge source 45
    pulse_set(45);
    do_read(8'h94, 32'h00002000, "R2 high raw");
    do_write(8'hA4, 32'h00002000);
    check("R3 high irq", {31'b0, irq_o}, 32'h1);
    do_read(8'h84, 32'h00002000, "R3 high status");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule